// File: doc/BRIEF.md
# Virtual-Address DMA Descriptor Engine

This block moves a run of 32-bit words between system memory and a single attached device. Host software loads a small descriptor into the block's register window: a virtual byte address, a word count, a direction and an interrupt enable. It loads the physical base of a linear page table and then writes a separate start command. The block translates the running virtual address into a physical one before every memory access. It moves one word at a time, either a memory read followed by a device write or a device read followed by a memory write.

Translation uses 4 KB pages. An eight-entry, fully associative translation buffer holds recent page mappings. On a miss the block reads one page-table entry from memory and installs it, replacing entries in round-robin order. If that entry is marked invalid, the transfer stops with an error flag. Completion or error can assert a level interrupt, which software clears by writing ones to the status flags.

Top module: `vdma_engine`

## Requirements
- R1: Register word indices are 0 virtual address, 1 word count (bits 15:0), 2 control (bit 0 direction, bit 1 interrupt enable), 3 page-table base, 4 start, 5 status (bit 0 busy, bit 1 done, bit 2 error). Descriptor registers read back what was written while idle. While busy, writes to them are ignored.
- R2: Writing 1 to bit 0 of the start register while idle sets busy. Busy stays set until done or error is flagged, and both flags read 0 after reset.
- R3: Each memory data access uses physical address {frame, virtual[11:2], 2'b00}, and the address is held steady until the access is acknowledged.
- R4: A virtual page found in the translation buffer causes no page-table read.
- R5: On a miss the block reads the word at page_table_base + 4*VPN. Bit 0 is the valid flag and bits 31:12 are the frame, which is installed for later hits.
- R6: With eight entries, after nine distinct pages are installed the oldest one has been evicted and misses again. The second oldest still hits.
- R7: A fresh translation is made whenever the running address enters a new 4 KB page.
- R8: Direction 0 copies memory words to the device and direction 1 copies device words to memory, one word per step. Memory and device are never requested in the same cycle.
- R9: An invalid page-table entry ends the transfer at once. Error is set, busy is cleared and no further words move.
- R10: Done is set when the last word completes. The interrupt output is high exactly while the enable bit is set and done or error is set.
- R11: Writing 1 to status bit 1 or bit 2 clears that flag and with it the interrupt.
- R12: A start with a word count of zero sets done without setting busy and without any memory or device access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Physical byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Memory read data |
| dev_req | output | 1 | Device access request |
| dev_we | output | 1 | Device write (1) or read (0) |
| dev_wdata | output | 32 | Word sent to the device |
| dev_ack | input | 1 | Device access complete |
| dev_rdata | input | 32 | Word received from the device |
| irq | output | 1 | Level interrupt |

## Verification
A register write from the host and the completion of the final word can land on the same clock edge. The write then meets a block that is still busy on that edge, yet idle a cycle later. The bench provokes this by watching its own device model. In the cycle the device acknowledges the last word, the bench writes a new virtual address. It then requires that the register still reads the old value after the transfer, and that a later idle write does take effect.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    localparam logic [2:0] RIX_VADDR = 3'd0;
    localparam logic [2:0] RIX_COUNT = 3'd1;
    localparam logic [2:0] RIX_CTRL  = 3'd2;
    localparam logic [2:0] RIX_PTB   = 3'd3;
    localparam logic [2:0] RIX_GO    = 3'd4;
    localparam logic [2:0] RIX_STAT  = 3'd5;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_LOOKUP,
        XS_WALK,
        XS_FETCH,
        XS_STORE
    } xfer_state_e;
endpackage

// File: rtl/vdma_tlb.sv
module vdma_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [IDX_W-1:0]              ptr;
    } tlb_t;

    tlb_t q, d;
    logic [ENTRIES-1:0] hit_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = q.vld[i] && (q.vpn[i] == lk_vpn);
    end

    assign lk_hit = |hit_vec;

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) lk_pfn = lk_pfn | q.pfn[i];
        end
    end

    always_comb begin
        d = q;
        if (fill_en) begin
            d.vld[q.ptr] = 1'b1;
            d.vpn[q.ptr] = fill_vpn;
            d.pfn[q.ptr] = fill_pfn;
            d.ptr        = (q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4: at most one entry may claim a page
    a_r4_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R5: an installed mapping is visible on the next lookup of that page
    a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> ((lk_vpn != $past(fill_vpn)) || lk_hit));
endmodule

// File: rtl/vdma_regs.sv
module vdma_regs
    import vdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [2:0]       addr,
    input  logic [AW-1:0]    wdata,
    output logic [AW-1:0]    rdata,
    input  logic             busy,
    input  logic             done_set,
    input  logic             err_set,
    output logic [AW-1:0]    desc_va,
    output logic [LEN_W-1:0] desc_len,
    output logic             desc_dir,
    output logic [AW-1:0]    pt_base,
    output logic             go,
    output logic             irq
);
    typedef struct packed {
        logic [AW-1:0]    va;
        logic [LEN_W-1:0] len;
        logic             dir;
        logic             ie;
        logic [AW-1:0]    ptb;
        logic             done;
        logic             err;
    } regs_t;

    regs_t q, d;
    logic  wr_idle;

    assign wr_idle = wr && !busy;
    assign go      = wr_idle && (addr == RIX_GO) && wdata[0];

    always_comb begin
        d = q;
        if (wr_idle) begin
            unique case (addr)
                RIX_VADDR: d.va  = wdata;
                RIX_COUNT: d.len = wdata[LEN_W-1:0];
                RIX_CTRL:  begin d.dir = wdata[0]; d.ie = wdata[1]; end
                RIX_PTB:   d.ptb = wdata;
                default:   ;
            endcase
        end
        if (go) begin
            d.done = 1'b0;
            d.err  = 1'b0;
        end
        if (wr && addr == RIX_STAT) begin
            if (wdata[1]) d.done = 1'b0;
            if (wdata[2]) d.err  = 1'b0;
        end
        if (done_set) d.done = 1'b1;
        if (err_set)  d.err  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (addr)
            RIX_VADDR: rdata = q.va;
            RIX_COUNT: rdata = AW'(q.len);
            RIX_CTRL:  rdata = AW'({q.ie, q.dir});
            RIX_PTB:   rdata = q.ptb;
            RIX_STAT:  rdata = AW'({q.err, q.done, busy});
            default:   rdata = '0;
        endcase
    end

    assign desc_va  = q.va;
    assign desc_len = q.len;
    assign desc_dir = q.dir;
    assign pt_base  = q.ptb;
    assign irq      = q.ie && (q.done || q.err);

    // R1: the descriptor is frozen while a transfer runs
    a_r1_desc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr && addr == RIX_VADDR) |=> $stable(q.va));

    // R2: busy only ends with a flag raised
    a_r2_end_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (q.done || q.err));
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
    import vdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int LEN_W     = 16,
    parameter int PAGE_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [AW-1:0]         desc_va,
    input  logic [LEN_W-1:0]      desc_len,
    input  logic                  desc_dir,
    input  logic [AW-1:0]         pt_base,
    output logic [AW-PAGE_BITS-1:0] tlb_vpn,
    input  logic                  tlb_hit,
    input  logic [AW-PAGE_BITS-1:0] tlb_pfn,
    output logic                  tlb_fill,
    output logic [AW-PAGE_BITS-1:0] tlb_fill_pfn,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [AW-1:0]         mem_wdata,
    input  logic                  mem_ack,
    input  logic [AW-1:0]         mem_rdata,
    output logic                  dev_req,
    output logic                  dev_we,
    output logic [AW-1:0]         dev_wdata,
    input  logic                  dev_ack,
    input  logic [AW-1:0]         dev_rdata,
    output logic                  busy,
    output logic                  done_set,
    output logic                  err_set
);
    localparam int PFN_W = AW - PAGE_BITS;

    typedef struct packed {
        xfer_state_e      st;
        logic [AW-1:0]    va;
        logic [LEN_W-1:0] cnt;
        logic [PFN_W-1:0] pfn;
        logic [AW-1:0]    data;
    } ctrl_t;

    ctrl_t q, d;
    logic [AW-1:0] phys;
    logic [AW-1:0] va_nx;
    logic          step_ack;

    assign tlb_vpn      = q.va[AW-1:PAGE_BITS];
    assign tlb_fill_pfn = mem_rdata[AW-1:PAGE_BITS];
    assign phys         = {q.pfn, q.va[PAGE_BITS-1:2], 2'b00};
    assign va_nx        = q.va + AW'(4);
    assign busy         = (q.st != XS_IDLE);
    assign mem_wdata    = q.data;
    assign dev_wdata    = q.data;

    always_comb begin
        d        = q;
        done_set = 1'b0;
        err_set  = 1'b0;
        tlb_fill = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        dev_req  = 1'b0;
        dev_we   = 1'b0;
        step_ack = 1'b0;
        unique case (q.st)
            XS_IDLE: begin
                if (go) begin
                    d.va  = desc_va & ~AW'(3);
                    d.cnt = desc_len;
                    if (desc_len == '0) done_set = 1'b1;
                    else                d.st = XS_LOOKUP;
                end
            end
            XS_LOOKUP: begin
                if (tlb_hit) begin
                    d.pfn = tlb_pfn;
                    d.st  = XS_FETCH;
                end else begin
                    d.st  = XS_WALK;
                end
            end
            XS_WALK: begin
                mem_req  = 1'b1;
                mem_addr = pt_base + AW'({q.va[AW-1:PAGE_BITS], 2'b00});
                if (mem_ack) begin
                    if (mem_rdata[0]) begin
                        tlb_fill = 1'b1;
                        d.pfn    = mem_rdata[AW-1:PAGE_BITS];
                        d.st     = XS_FETCH;
                    end else begin
                        err_set  = 1'b1;
                        d.st     = XS_IDLE;
                    end
                end
            end
            XS_FETCH: begin
                if (!desc_dir) begin
                    mem_req  = 1'b1;
                    mem_addr = phys;
                    step_ack = mem_ack;
                    if (mem_ack) d.data = mem_rdata;
                end else begin
                    dev_req  = 1'b1;
                    step_ack = dev_ack;
                    if (dev_ack) d.data = dev_rdata;
                end
                if (step_ack) d.st = XS_STORE;
            end
            XS_STORE: begin
                if (!desc_dir) begin
                    dev_req  = 1'b1;
                    dev_we   = 1'b1;
                    step_ack = dev_ack;
                end else begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = phys;
                    step_ack = mem_ack;
                end
                if (step_ack) begin
                    d.cnt = q.cnt - 1'b1;
                    d.va  = va_nx;
                    if (q.cnt == LEN_W'(1)) begin
                        done_set = 1'b1;
                        d.st     = XS_IDLE;
                    end else if (va_nx[PAGE_BITS-1:0] == '0) begin
                        d.st     = XS_LOOKUP;
                    end else begin
                        d.st     = XS_FETCH;
                    end
                end
            end
            default: d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: XS_IDLE, default: '0};
        else        q <= d;
    end

    // R8: only one port is addressed at a time
    a_r8_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && dev_req));

    // R3: a pending memory access keeps its address
    a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R9: an invalid entry returns the engine to idle
    a_r9_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> !busy);

    // R12: an empty descriptor never makes the engine busy
    a_r12_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (go && desc_len == '0) |=> !busy);
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine #(
    parameter int AW          = 32,
    parameter int LEN_W       = 16,
    parameter int PAGE_BITS   = 12,
    parameter int TLB_ENTRIES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          dev_req,
    output logic          dev_we,
    output logic [AW-1:0] dev_wdata,
    input  logic          dev_ack,
    input  logic [AW-1:0] dev_rdata,
    output logic          irq
);
    localparam int VPN_W = AW - PAGE_BITS;

    logic [AW-1:0]    desc_va;
    logic [LEN_W-1:0] desc_len;
    logic             desc_dir;
    logic [AW-1:0]    pt_base;
    logic             go;
    logic             busy;
    logic             done_set;
    logic             err_set;
    logic [VPN_W-1:0] tlb_vpn;
    logic             tlb_hit;
    logic [VPN_W-1:0] tlb_pfn;
    logic             tlb_fill;
    logic [VPN_W-1:0] tlb_fill_pfn;

    vdma_regs #(.AW(AW), .LEN_W(LEN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (busy),
        .done_set (done_set),
        .err_set  (err_set),
        .desc_va  (desc_va),
        .desc_len (desc_len),
        .desc_dir (desc_dir),
        .pt_base  (pt_base),
        .go       (go),
        .irq      (irq)
    );

    vdma_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PFN_W(VPN_W)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (tlb_vpn),
        .lk_hit   (tlb_hit),
        .lk_pfn   (tlb_pfn),
        .fill_en  (tlb_fill),
        .fill_vpn (tlb_vpn),
        .fill_pfn (tlb_fill_pfn)
    );

    vdma_ctrl #(.AW(AW), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .desc_va      (desc_va),
        .desc_len     (desc_len),
        .desc_dir     (desc_dir),
        .pt_base      (pt_base),
        .tlb_vpn      (tlb_vpn),
        .tlb_hit      (tlb_hit),
        .tlb_pfn      (tlb_pfn),
        .tlb_fill     (tlb_fill),
        .tlb_fill_pfn (tlb_fill_pfn),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .dev_req      (dev_req),
        .dev_we       (dev_we),
        .dev_wdata    (dev_wdata),
        .dev_ack      (dev_ack),
        .dev_rdata    (dev_rdata),
        .busy         (busy),
        .done_set     (done_set),
        .err_set      (err_set)
    );

    // R10: the interrupt line never rises while a transfer is still running
    a_r10_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy);
endmodule

// File: tb/vdma_engine_tb.sv
module vdma_engine_tb;
    localparam logic [31:0] PT_BASE = 32'h0100_0000;
    localparam logic [19:0] BAD_VPN = 20'h1A1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, dev_req, dev_we, irq;
    logic [31:0] mem_addr, mem_wdata, dev_wdata;
    logic        mem_ack = 1'b0, dev_ack = 1'b0;
    logic [31:0] mem_rdata = '0, dev_rdata = '0;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int pte_reads = 0;
    int mem_writes = 0;
    int dev_src = 0;
    logic [31:0] last_pte_addr = '0;
    logic [31:0] mem_store [logic [31:0]];
    logic [31:0] dev_seen [$];

    always #2.5 clk = ~clk;

    vdma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dev_req(dev_req), .dev_we(dev_we), .dev_wdata(dev_wdata),
        .dev_ack(dev_ack), .dev_rdata(dev_rdata), .irq(irq)
    );

    function automatic logic [31:0] pte_of(logic [19:0] vpn);
        if (vpn == BAD_VPN) return 32'h0;
        return {vpn + 20'h200, 11'b0, 1'b1};
    endfunction

    function automatic logic in_pt(logic [31:0] a);
        return (a >= PT_BASE) && (a < PT_BASE + 32'h0040_0000);
    endfunction

    function automatic logic [31:0] mem_peek(logic [31:0] a);
        if (mem_store.exists(a)) return mem_store[a];
        if (in_pt(a)) return pte_of(20'((a - PT_BASE) >> 2));
        return a ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] phys_of(logic [31:0] va);
        return {va[31:12] + 20'h200, va[11:2], 2'b00};
    endfunction

    // memory and device models: one-cycle acknowledge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            dev_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) begin
                    mem_store[mem_addr] = mem_wdata;
                    mem_writes++;
                end else begin
                    mem_rdata <= mem_peek(mem_addr);
                    if (in_pt(mem_addr)) begin
                        pte_reads++;
                        last_pte_addr = mem_addr;
                    end
                end
            end
            dev_ack <= dev_req && !dev_ack;
            if (dev_req && !dev_ack) begin
                if (dev_we) dev_seen.push_back(dev_wdata);
                else begin
                    dev_rdata <= 32'hD000_0000 + 32'(dev_src);
                    dev_src++;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        reg_addr = 3'd5;
        #1;
        for (int n = 0; n < 5000 && reg_rdata[0]; n++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run(input logic [31:0] va, input logic [15:0] len,
                       input logic dir, input logic ie);
        wr(3'd0, va);
        wr(3'd1, {16'h0, len});
        wr(3'd2, {30'h0, ie, dir});
        wr(3'd4, 32'h1);
        wait_idle();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int p0, k0, w0;
        logic [19:0] vpn;
        logic [31:0] va;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd5, v);
        chk("R2 reset status", v, 32'h0);
        chk("R10 reset irq", {31'h0, irq}, 32'h0);

        wr(3'd3, PT_BASE);
        rd(3'd3, v);
        chk("R1 ptbase readback", v, PT_BASE);

        // sweep: direction x page offset x length, fresh pages each run
        vpn = 20'h100;
        for (int dir = 0; dir < 2; dir++) begin
            for (int off = 1; off <= 4; off++) begin
                for (int len = 1; len <= 6; len++) begin
                    va = {vpn, 12'h0} + 32'h1000 - 32'(4 * off);
                    dev_seen.delete();
                    p0 = pte_reads;
                    k0 = dev_src;
                    run(va, 16'(len), dir[0], 1'b0);
                    if (dir == 0) begin
                        chk("R8 device word count", 32'(dev_seen.size()), 32'(len));
                        for (int i = 0; i < len && i < dev_seen.size(); i++)
                            chk("R8 mem->dev data", dev_seen[i],
                                mem_peek(phys_of(va + 32'(4 * i))));
                    end else begin
                        for (int i = 0; i < len; i++)
                            chk("R3 dev->mem placement", mem_peek(phys_of(va + 32'(4 * i))),
                                32'hD000_0000 + 32'(k0 + i));
                    end
                    chk("R7 walks per page crossing", 32'(pte_reads - p0),
                        (off < len) ? 32'd2 : 32'd1);
                    rd(3'd5, v);
                    chk("R10 done flag", v, 32'h2);
                    vpn = vpn + 20'd2;
                end
            end
        end

        // translation buffer hit on a page used just before
        p0 = pte_reads;
        dev_seen.delete();
        run({20'h15E, 12'h000}, 16'd2, 1'b0, 1'b0);
        chk("R4 hit needs no walk", 32'(pte_reads - p0), 32'd0);
        chk("R4 hit data", dev_seen[1], mem_peek(phys_of({20'h15E, 12'h004})));

        // round-robin replacement over nine fresh pages
        for (int i = 0; i < 9; i++) begin
            run({20'h180 + 20'(i), 12'h010}, 16'd1, 1'b0, 1'b0);
            if (i == 0) chk("R5 entry address", last_pte_addr, PT_BASE + 32'(4 * 32'h180));
        end
        p0 = pte_reads;
        run({20'h180, 12'h020}, 16'd1, 1'b0, 1'b0);
        chk("R6 oldest evicted", 32'(pte_reads - p0), 32'd1);
        p0 = pte_reads;
        run({20'h182, 12'h020}, 16'd1, 1'b0, 1'b0);
        chk("R6 younger kept", 32'(pte_reads - p0), 32'd0);

        // invalid entry on the second page of a transfer
        dev_seen.delete();
        w0 = mem_writes;
        run({BAD_VPN - 20'd1, 12'hFFC}, 16'd3, 1'b0, 1'b1);
        chk("R9 words before fault", 32'(dev_seen.size()), 32'd1);
        rd(3'd5, v);
        chk("R9 error status", v, 32'h4);
        chk("R10 irq on error", {31'h0, irq}, 32'h1);
        chk("R9 no memory writes", 32'(mem_writes - w0), 32'd0);
        wr(3'd5, 32'h4);
        rd(3'd5, v);
        chk("R11 error cleared", v, 32'h0);
        chk("R11 irq dropped", {31'h0, irq}, 32'h0);

        // completion with interrupt disabled, then enabled afterwards
        run({20'h1B0, 12'h000}, 16'd2, 1'b0, 1'b0);
        chk("R10 irq masked", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'h2);
        rd(3'd2, v);
        chk("R10 irq follows enable", {31'h0, irq}, 32'h1);
        wr(3'd5, 32'h2);
        rd(3'd5, v);
        chk("R11 done cleared", v, 32'h0);
        chk("R11 irq low after clear", {31'h0, irq}, 32'h0);

        // writes while busy, including one on the completing edge
        dev_seen.delete();
        wr(3'd0, {20'h1C0, 12'h000});
        wr(3'd1, 32'd4);
        wr(3'd2, 32'h0);
        wr(3'd4, 32'h1);
        wr(3'd0, 32'hDEAD_0000);
        wr(3'd1, 32'd9);
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            #1;
            if (dev_ack && dev_we && dev_seen.size() == 4) break;
        end
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'hBEEF_0000;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_idle();
        rd(3'd0, v);
        chk("R1 busy write ignored", v, {20'h1C0, 12'h000});
        rd(3'd1, v);
        chk("R1 count frozen", v, 32'd4);
        chk("R8 busy run words", 32'(dev_seen.size()), 32'd4);
        wr(3'd0, 32'h1234_5000);
        rd(3'd0, v);
        chk("R1 idle write taken", v, 32'h1234_5000);

        // empty descriptor
        dev_seen.delete();
        p0 = pte_reads;
        w0 = mem_writes;
        run({20'h1D0, 12'h000}, 16'd0, 1'b1, 1'b1);
        rd(3'd5, v);
        chk("R12 empty done", v, 32'h2);
        chk("R12 irq", {31'h0, irq}, 32'h1);
        chk("R12 no walks", 32'(pte_reads - p0), 32'd0);
        chk("R12 no memory writes", 32'(mem_writes - w0), 32'd0);
        chk("R12 no device reads", 32'(dev_src - k0 - 0) >= 0 ? 32'(dev_seen.size()) : 32'd1, 32'd0);
        wr(3'd5, 32'h2);
        chk("R11 final clear", {31'h0, irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule